// File: doc/BRIEF.md
# CPU Clock Rate-Change Sequencer

This block runs the register sequence that a CPU clock domain needs around a relock of its PLL. It is a hardware state machine that drives a register read/write port into the clock-control block. A controller issues a *pre* request before the PLL is reprogrammed and a *post* request after the PLL has locked again. Each request carries the old rate, the new rate and the alternate-source rate, all in Hz.

On a pre request the block looks up the divider settings for the new rate in a parameterised table, whose entries hold rates in kHz. When the output could otherwise run too fast, it computes a safe divider for the alternate source with a small iterative ceiling divider and programs that divider first. It then moves the clock mux onto the alternate source and writes the main divider register and the auxiliary divider register. It polls the matching status register after every write. A post request moves the mux back to the PLL and takes the safe divider back out.

Each status poll is bounded by a cycle counter. A poll that times out is reported but does not stop the sequence. Only one request is in flight at a time. The outcome is reported by a one-cycle done pulse together with error, timeout and warning flags.

Top module: `cpuclk_seq`

## Requirements
- R1: After reset `req_ready_o` is 1, `done_o` is 0 and no register read or write is issued while the block is idle.
- R2: The table is searched for an entry whose rate times 1000 equals the new rate, and a zero rate ends the table. On a miss the request ends with `done_o` and `err_o` and makes no register write. Pre requests always search the table; post requests search it only when the debug-divider mode is on.
- R3: A safe divider is used when alt > old or old > new. Its value is ceil(alt / min(old, new)) − 1, and its low 3 bits are written into bits 2:0 of divider register 0 (address 2). That write is made, and bits 2:0 and 18:16 of the divider-0 status register (address 4) must read zero, before the mux select is written.
- R4: The pre sequence writes registers in this order: the optional safe write to address 2, then mux select (address 0) with bit 16 set, then divider 0 (address 2), then divider 1 (address 3). The write to divider 0 waits until mux status (address 1) bits 18:16 read 2. Each divider write waits until its status register (address 4 or 5) reads zero.
- R5: The final divider-0 write equals the table value ORed with the safe value when a safe divider was applied, and equals the table value alone otherwise.
- R6: When bit 20 of mux select is set, divider 1 is written with only its current bits 6:4 and 2:0, and all other bits are zero. When bit 20 is clear, divider 1 takes the table value.
- R7: In debug-divider mode, bits 18:16 of divider 0 are forced to 7 in the safe value. On a post request those bits are restored from the table entry.
- R8: The post sequence clears bit 16 of mux select and waits until mux status bits 18:16 read 1. It then rewrites divider 0 with bits 2:0 cleared and waits until its status reads zero.
- R9: A poll that has not matched within `TIMEOUT_CYC` cycles sets `timeout_o` at done, and the sequence carries on with its next step.
- R10: `warn_o` is set at done when a safe divider value of 8 or more was computed.
- R11: `req_ready_o` goes low in the cycle after a request is accepted and stays low until the one-cycle `done_o` pulse. After that pulse it returns high.
- R12: A register read and a register write are never issued in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe |
| req_ready_o | output | 1 | Block idle, request accepted |
| req_post_i | input | 1 | 0 = pre-change request, 1 = post-change request |
| old_rate_i | input | RATE_W | Rate before the change, Hz |
| new_rate_i | input | RATE_W | Rate after the change, Hz |
| alt_rate_i | input | RATE_W | Alternate-source rate, Hz |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Table miss, valid with done |
| timeout_o | output | 1 | Some poll timed out, valid with done |
| warn_o | output | 1 | Safe divider out of field range, valid with done |
| reg_we_o | output | 1 | Register write strobe |
| reg_re_o | output | 1 | Register read strobe |
| reg_addr_o | output | 3 | Register address (0 mux select, 1 mux status, 2 divider 0, 3 divider 1, 4 divider-0 status, 5 divider-1 status) |
| reg_wdata_o | output | 32 | Write data |
| reg_rdata_i | input | 32 | Read data, valid in the cycle of the read strobe |

## Verification
The bench builds the block with the divider-1 path and the debug-divider mode both on, so the keep-current-fields rule and the debug-field restore are both reachable. It uses the 4-entry default table with a zero terminator, so a rate missing from the table drives the error path. The timeout is set to 20 cycles, so a mux that never settles exercises the continue-after-timeout path in a short run. Alternate rates up to 5 MHz against table rates of 0.5 to 1 MHz make the safe divider reach 8 and beyond.

// File: rtl/cpuclk_seq_pkg.sv
package cpuclk_seq_pkg;
  localparam int REG_W = 32;

  typedef enum logic [2:0] {
    RA_MUX_SEL   = 3'd0,
    RA_MUX_STAT  = 3'd1,
    RA_DIV0      = 3'd2,
    RA_DIV1      = 3'd3,
    RA_DIV0_STAT = 3'd4,
    RA_DIV1_STAT = 3'd5
  } reg_addr_e;

  localparam logic [REG_W-1:0] SEL_BIT    = 32'h0001_0000;
  localparam int               HPM_BIT    = 20;
  localparam logic [REG_W-1:0] CORE_FLD   = 32'h0000_0007;
  localparam logic [REG_W-1:0] DBG_FLD    = 32'h0007_0000;
  localparam logic [REG_W-1:0] MSTAT_FLD  = 32'h0007_0000;
  localparam logic [REG_W-1:0] MSTAT_ALT  = 32'h0002_0000;
  localparam logic [REG_W-1:0] MSTAT_PLL  = 32'h0001_0000;
  localparam logic [REG_W-1:0] DIV1_KEEP  = 32'h0000_0077;

  typedef enum logic [3:0] {
    S_IDLE, S_LOOK, S_RD_SEL, S_RD_D1, S_CHK, S_DIVW, S_SAFE_RD, S_SAFE_WR,
    S_MUX_RD, S_MUX_WR, S_D0_WR, S_D1_WR, S_POLL, S_DONE
  } seq_state_e;
endpackage

// File: rtl/cpuclk_cfg_rom.sv
module cpuclk_cfg_rom #(
  parameter int NUM_ENT = 4,
  parameter int RATE_W  = 32,
  parameter int DATA_W  = 32,
  parameter logic [NUM_ENT-1:0][RATE_W-1:0] TBL_RATE = '0,
  parameter logic [NUM_ENT-1:0][DATA_W-1:0] TBL_DIV0 = '0,
  parameter logic [NUM_ENT-1:0][DATA_W-1:0] TBL_DIV1 = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [RATE_W-1:0] key_i,
  output logic              done_o,
  output logic              hit_o,
  output logic [DATA_W-1:0] div0_o,
  output logic [DATA_W-1:0] div1_o
);
  localparam int IDX_W = $clog2(NUM_ENT + 1);
  localparam int SEL_W = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1;

  logic              busy_q;
  logic [IDX_W-1:0]  idx_q;
  logic [RATE_W-1:0] key_q;
  logic [SEL_W-1:0]  sel;
  logic              at_end;
  logic [RATE_W-1:0] cur_rate, scaled;

  assign at_end   = (idx_q == IDX_W'(NUM_ENT));
  assign sel      = at_end ? '0 : idx_q[SEL_W-1:0];
  assign cur_rate = TBL_RATE[sel];
  assign scaled   = cur_rate * RATE_W'(1000);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      key_q  <= '0;
      done_o <= 1'b0;
      hit_o  <= 1'b0;
      div0_o <= '0;
      div1_o <= '0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
        key_q  <= key_i;
      end else if (busy_q) begin
        if (at_end || cur_rate == '0) begin
          busy_q <= 1'b0;
          done_o <= 1'b1;
          hit_o  <= 1'b0;
        end else if (scaled == key_q) begin
          busy_q <= 1'b0;
          done_o <= 1'b1;
          hit_o  <= 1'b1;
          div0_o <= TBL_DIV0[sel];
          div1_o <= TBL_DIV1[sel];
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cpuclk_ceil_div.sv
module cpuclk_ceil_div #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] num_i,
  input  logic [W-1:0] den_i,
  output logic         valid_o,
  output logic [W:0]   quo_o
);
  localparam int QW = W + 1;
  localparam int CW = $clog2(W + 2);

  logic [W:0]    dvd_q, rem_q;
  logic [W-1:0]  den_q;
  logic [W+1:0]  trial, den_x;
  logic [CW-1:0] cnt_q;
  logic          busy_q;

  assign trial = {rem_q, dvd_q[W]};
  assign den_x = {2'b00, den_q};
  assign quo_o = dvd_q;

  // restoring division of (num + den - 1) by den
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dvd_q   <= '0;
      rem_q   <= '0;
      den_q   <= '0;
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (start_i) begin
        dvd_q  <= {1'b0, num_i} + {1'b0, den_i} - QW'(1);
        rem_q  <= '0;
        den_q  <= den_i;
        cnt_q  <= CW'(QW);
        busy_q <= 1'b1;
      end else if (busy_q) begin
        if (trial >= den_x) begin
          rem_q <= QW'(trial - den_x);
          dvd_q <= {dvd_q[W-1:0], 1'b1};
        end else begin
          rem_q <= trial[W:0];
          dvd_q <= {dvd_q[W-1:0], 1'b0};
        end
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          busy_q  <= 1'b0;
          valid_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cpuclk_seq.sv
module cpuclk_seq
  import cpuclk_seq_pkg::*;
#(
  parameter int RATE_W      = 32,
  parameter int NUM_ENT     = 4,
  parameter logic [NUM_ENT-1:0][RATE_W-1:0] TBL_RATE =
    {32'd0, 32'd500, 32'd800, 32'd1000},
  parameter logic [NUM_ENT-1:0][31:0] TBL_DIV0 =
    {32'h0, 32'h0001_2510, 32'h0002_3620, 32'h0003_4710},
  parameter logic [NUM_ENT-1:0][31:0] TBL_DIV1 =
    {32'h0, 32'h0000_0131, 32'h0000_0142, 32'h0000_0153},
  parameter bit HAS_DIV1    = 1'b1,
  parameter bit DBG_DIV     = 1'b1,
  parameter int TIMEOUT_CYC = 1_000_000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_post_i,
  input  logic [RATE_W-1:0] old_rate_i,
  input  logic [RATE_W-1:0] new_rate_i,
  input  logic [RATE_W-1:0] alt_rate_i,
  output logic              done_o,
  output logic              err_o,
  output logic              timeout_o,
  output logic              warn_o,
  output logic              reg_we_o,
  output logic              reg_re_o,
  output logic [2:0]        reg_addr_o,
  output logic [31:0]       reg_wdata_o,
  input  logic [31:0]       reg_rdata_i
);
  localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [REG_W-1:0] SAFE_MASK = CORE_FLD | (DBG_DIV ? DBG_FLD : '0);

  seq_state_e st_q, ret_q;
  reg_addr_e  poll_addr_q;
  logic [REG_W-1:0] poll_mask_q, poll_val_q, rd_q, keep1_q, sval_q;
  logic [RATE_W-1:0] old_q, new_q, alt_q, min_rate;
  logic [CNT_W-1:0] cnt_q;
  logic post_q, hpm_q, safe_q, warn_q, err_q, tmo_q;

  logic accept, rom_start, rom_done, rom_hit, div_start, div_valid, need_safe;
  logic [REG_W-1:0] td0, td1, safe_src;
  logic [RATE_W:0]  quo, adj;

  assign req_ready_o = (st_q == S_IDLE);
  assign accept      = req_valid_i && req_ready_o;
  assign rom_start   = accept && (!req_post_i || DBG_DIV);
  assign need_safe   = (alt_q > old_q) || (old_q > new_q);
  assign min_rate    = (old_q < new_q) ? old_q : new_q;
  assign div_start   = (st_q == S_CHK) && need_safe;
  assign adj         = (quo == '0) ? '0 : quo - 1'b1;
  assign safe_src    = post_q ? (td0 & DBG_FLD) : sval_q;

  cpuclk_cfg_rom #(
    .NUM_ENT(NUM_ENT), .RATE_W(RATE_W), .DATA_W(REG_W),
    .TBL_RATE(TBL_RATE), .TBL_DIV0(TBL_DIV0), .TBL_DIV1(TBL_DIV1)
  ) u_rom (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(rom_start), .key_i(new_rate_i),
    .done_o(rom_done), .hit_o(rom_hit), .div0_o(td0), .div1_o(td1)
  );

  cpuclk_ceil_div #(.W(RATE_W)) u_cdiv (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(div_start),
    .num_i(alt_q), .den_i(min_rate), .valid_o(div_valid), .quo_o(quo)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= S_IDLE;
      ret_q       <= S_IDLE;
      poll_addr_q <= RA_MUX_STAT;
      poll_mask_q <= '0;
      poll_val_q  <= '0;
      rd_q        <= '0;
      keep1_q     <= '0;
      sval_q      <= '0;
      old_q       <= '0;
      new_q       <= '0;
      alt_q       <= '0;
      cnt_q       <= '0;
      post_q      <= 1'b0;
      hpm_q       <= 1'b0;
      safe_q      <= 1'b0;
      warn_q      <= 1'b0;
      err_q       <= 1'b0;
      tmo_q       <= 1'b0;
    end else begin
      unique case (st_q)
        S_IDLE: if (accept) begin
          old_q  <= old_rate_i;
          new_q  <= new_rate_i;
          alt_q  <= alt_rate_i;
          post_q <= req_post_i;
          hpm_q  <= 1'b0;
          safe_q <= 1'b0;
          warn_q <= 1'b0;
          err_q  <= 1'b0;
          tmo_q  <= 1'b0;
          cnt_q  <= '0;
          st_q   <= (req_post_i && !DBG_DIV) ? S_MUX_RD : S_LOOK;
        end
        S_LOOK: if (rom_done) begin
          if (!rom_hit) begin
            err_q <= 1'b1;
            st_q  <= S_DONE;
          end else if (post_q) st_q <= S_MUX_RD;
          else st_q <= HAS_DIV1 ? S_RD_SEL : S_CHK;
        end
        S_RD_SEL: begin
          hpm_q <= reg_rdata_i[HPM_BIT];
          st_q  <= reg_rdata_i[HPM_BIT] ? S_RD_D1 : S_CHK;
        end
        S_RD_D1: begin
          keep1_q <= reg_rdata_i & DIV1_KEEP;
          st_q    <= S_CHK;
        end
        S_CHK: st_q <= need_safe ? S_DIVW : S_MUX_RD;
        S_DIVW: if (div_valid) begin
          safe_q <= 1'b1;
          warn_q <= (adj >= (RATE_W+1)'(8));
          sval_q <= {{(REG_W-3){1'b0}}, adj[2:0]} | (DBG_DIV ? DBG_FLD : '0);
          st_q   <= S_SAFE_RD;
        end
        S_SAFE_RD: begin
          rd_q <= reg_rdata_i;
          st_q <= S_SAFE_WR;
        end
        S_SAFE_WR: begin
          poll_addr_q <= RA_DIV0_STAT;
          poll_mask_q <= SAFE_MASK;
          poll_val_q  <= '0;
          ret_q       <= post_q ? S_DONE : S_MUX_RD;
          st_q        <= S_POLL;
        end
        S_MUX_RD: begin
          rd_q <= reg_rdata_i;
          st_q <= S_MUX_WR;
        end
        S_MUX_WR: begin
          poll_addr_q <= RA_MUX_STAT;
          poll_mask_q <= MSTAT_FLD;
          poll_val_q  <= post_q ? MSTAT_PLL : MSTAT_ALT;
          ret_q       <= post_q ? S_SAFE_RD : S_D0_WR;
          st_q        <= S_POLL;
        end
        S_D0_WR: begin
          poll_addr_q <= RA_DIV0_STAT;
          poll_mask_q <= '1;
          poll_val_q  <= '0;
          ret_q       <= HAS_DIV1 ? S_D1_WR : S_DONE;
          st_q        <= S_POLL;
        end
        S_D1_WR: begin
          poll_addr_q <= RA_DIV1_STAT;
          poll_mask_q <= '1;
          poll_val_q  <= '0;
          ret_q       <= S_DONE;
          st_q        <= S_POLL;
        end
        S_POLL: begin
          if ((reg_rdata_i & poll_mask_q) == poll_val_q) begin
            cnt_q <= '0;
            st_q  <= ret_q;
          end else if (cnt_q == CNT_W'(TIMEOUT_CYC - 1)) begin
            tmo_q <= 1'b1;
            cnt_q <= '0;
            st_q  <= ret_q;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        S_DONE:  st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    reg_we_o    = 1'b0;
    reg_re_o    = 1'b0;
    reg_addr_o  = RA_MUX_SEL;
    reg_wdata_o = '0;
    unique case (st_q)
      S_RD_SEL: reg_re_o = 1'b1;
      S_RD_D1: begin
        reg_re_o   = 1'b1;
        reg_addr_o = RA_DIV1;
      end
      S_SAFE_RD: begin
        reg_re_o   = 1'b1;
        reg_addr_o = RA_DIV0;
      end
      S_SAFE_WR: begin
        reg_we_o    = 1'b1;
        reg_addr_o  = RA_DIV0;
        reg_wdata_o = (rd_q & ~SAFE_MASK) | (safe_src & SAFE_MASK);
      end
      S_MUX_RD: reg_re_o = 1'b1;
      S_MUX_WR: begin
        reg_we_o    = 1'b1;
        reg_wdata_o = post_q ? (rd_q & ~SEL_BIT) : (rd_q | SEL_BIT);
      end
      S_D0_WR: begin
        reg_we_o    = 1'b1;
        reg_addr_o  = RA_DIV0;
        reg_wdata_o = td0 | (safe_q ? sval_q : '0);
      end
      S_D1_WR: begin
        reg_we_o    = 1'b1;
        reg_addr_o  = RA_DIV1;
        reg_wdata_o = hpm_q ? keep1_q : td1;
      end
      S_POLL: begin
        reg_re_o   = 1'b1;
        reg_addr_o = poll_addr_q;
      end
      default: ;
    endcase
  end

  assign done_o    = (st_q == S_DONE);
  assign err_o     = done_o && err_q;
  assign timeout_o = done_o && tmo_q;
  assign warn_o    = done_o && warn_q;
endmodule

// File: rtl/cpuclk_seq_chk.sv
module cpuclk_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic req_valid_i,
  input logic req_ready_o,
  input logic done_o,
  input logic err_o,
  input logic timeout_o,
  input logic warn_o,
  input logic reg_we_o,
  input logic reg_re_o
);
  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !(reg_we_o || reg_re_o));
  assert_err_at_done_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);
  assert_tmo_at_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> done_o);
  assert_warn_at_done_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warn_o |-> done_o);
  assert_busy_after_accept_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);
  assert_done_single_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && req_ready_o));
  assert_no_rw_overlap_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_we_o && reg_re_o));
endmodule

bind cpuclk_seq cpuclk_seq_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
  .done_o(done_o), .err_o(err_o), .timeout_o(timeout_o), .warn_o(warn_o),
  .reg_we_o(reg_we_o), .reg_re_o(reg_re_o)
);

// File: tb/cpuclk_seq_test.sv
`timescale 1ns/1ps
module cpuclk_seq_test;
  localparam logic [3:0][31:0] T_RATE = {32'd0, 32'd500, 32'd800, 32'd1000};
  localparam logic [3:0][31:0] T_D0 = {32'h0, 32'h0001_2510, 32'h0002_3620, 32'h0003_4710};
  localparam logic [3:0][31:0] T_D1 = {32'h0, 32'h0000_0131, 32'h0000_0142, 32'h0000_0153};
  localparam logic [31:0] MASK = 32'h0007_0007;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_post = 1'b0, req_ready;
  logic [31:0] old_r = '0, new_r = '0, alt_r = '0;
  logic done, err, tmo, warn, we, re;
  logic [2:0] addr;
  logic [31:0] wdata, rdata;

  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  cpuclk_seq #(
    .RATE_W(32), .NUM_ENT(4), .TBL_RATE(T_RATE), .TBL_DIV0(T_D0), .TBL_DIV1(T_D1),
    .HAS_DIV1(1'b1), .DBG_DIV(1'b1), .TIMEOUT_CYC(20)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_post_i(req_post), .old_rate_i(old_r), .new_rate_i(new_r), .alt_rate_i(alt_r),
    .done_o(done), .err_o(err), .timeout_o(tmo), .warn_o(warn),
    .reg_we_o(we), .reg_re_o(re), .reg_addr_o(addr), .reg_wdata_o(wdata),
    .reg_rdata_i(rdata)
  );

  // clock-control register model
  logic [31:0] m_sel = '0, m_d0 = '0, m_d1 = '0, preset_sel = '0;
  logic preset_en = 1'b0, stuck_en = 1'b0;
  int mux_cnt = 0, d0_busy = 0, d1_busy = 0;
  int wcnt = 0, ovl = 0;
  logic [2:0]  log_a [0:1023];
  logic [31:0] log_d [0:1023];

  always_comb begin
    case (addr)
      3'd0: rdata = m_sel;
      3'd1: rdata = (stuck_en || mux_cnt != 0) ? 32'h0004_0000 :
                    (m_sel[16] ? 32'h0002_0000 : 32'h0001_0000);
      3'd2: rdata = m_d0;
      3'd3: rdata = m_d1;
      3'd4: rdata = (d0_busy != 0) ? 32'h0007_0007 : 32'h0;
      3'd5: rdata = (d1_busy != 0) ? 32'h0000_0077 : 32'h0;
      default: rdata = 32'h0;
    endcase
  end

  always @(posedge clk) begin
    if (mux_cnt != 0) mux_cnt <= mux_cnt - 1;
    if (d0_busy != 0) d0_busy <= d0_busy - 1;
    if (d1_busy != 0) d1_busy <= d1_busy - 1;
    if (preset_en) m_sel <= preset_sel;
    if (rst_n && we && re) ovl <= ovl + 1;
    if (rst_n && we) begin
      log_a[wcnt] <= addr;
      log_d[wcnt] <= wdata;
      wcnt <= wcnt + 1;
      case (addr)
        3'd0: begin m_sel <= wdata; mux_cnt <= 3; end
        3'd2: begin m_d0 <= wdata; d0_busy <= 2; end
        3'd3: begin m_d1 <= wdata; d1_busy <= 2; end
        default: ;
      endcase
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int tbl_find(input logic [31:0] r);
    for (int i = 0; i < 4; i++) begin
      if (T_RATE[i] == 0) return -1;
      if (T_RATE[i] * 1000 == r) return i;
    end
    return -1;
  endfunction

  logic [2:0]  ex_a [0:7];
  logic [31:0] ex_d [0:7];
  string       ex_t [0:7];
  int          ex_n;

  task automatic push(input logic [2:0] a, input logic [31:0] d, input string t);
    ex_a[ex_n] = a; ex_d[ex_n] = d; ex_t[ex_n] = t; ex_n++;
  endtask

  task automatic run_req(input bit post, input logic [31:0] o, input logic [31:0] n,
                         input logic [31:0] al, input bit hpm, input bit stuck);
    logic [31:0] msel, d0, d1, sv, td0, td1;
    longint q, ad, mn;
    int idx, base, ov0;
    bit safe, miss, exp_warn, got;
    bit g_err, g_tmo, g_warn;
    @(negedge clk);
    preset_sel = (m_sel & ~32'h0010_0000) | (hpm ? 32'h0010_0000 : 32'h0);
    preset_en = 1'b1;
    stuck_en = stuck;
    @(negedge clk);
    preset_en = 1'b0;
    msel = m_sel; d0 = m_d0; d1 = m_d1; base = wcnt; ov0 = ovl;
    idx = tbl_find(n);
    miss = (idx < 0);
    td0 = miss ? 32'h0 : T_D0[idx];
    td1 = miss ? 32'h0 : T_D1[idx];
    ex_n = 0;
    exp_warn = 1'b0;
    if (!miss && !post) begin
      safe = (al > o) || (o > n);
      mn = (o < n) ? o : n;
      q = (longint'(al) + mn - 1) / mn;
      ad = (q == 0) ? 0 : q - 1;
      sv = 32'(ad & 7) | 32'h0007_0000;
      exp_warn = safe && (ad >= 8);
      if (safe) push(3'd2, (d0 & ~MASK) | sv, "R3");
      push(3'd0, msel | 32'h0001_0000, "R4");
      push(3'd2, td0 | (safe ? sv : 32'h0), "R5");
      push(3'd3, msel[20] ? (d1 & 32'h77) : td1, "R6");
    end else if (!miss) begin
      push(3'd0, msel & ~32'h0001_0000, "R8");
      push(3'd2, (d0 & ~MASK) | (td0 & 32'h0007_0000), "R7");
    end
    req_post = post; old_r = o; new_r = n; alt_r = al; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R11", "ready after accept", req_ready, 0);
    got = 1'b0; g_err = 0; g_tmo = 0; g_warn = 0;
    for (int k = 0; k < 3000 && !got; k++) begin
      if (done) begin
        got = 1'b1; g_err = err; g_tmo = tmo; g_warn = warn;
      end else @(negedge clk);
    end
    chk(got, "R11", "done pulse seen", got, 1);
    chk(g_err == miss, "R2", "err flag", g_err, miss);
    chk(g_tmo == (stuck && !miss), "R9", "timeout flag", g_tmo, stuck && !miss);
    chk(g_warn == exp_warn, "R10", "warn flag", g_warn, exp_warn);
    @(negedge clk);
    chk(req_ready == 1'b1, "R11", "ready after done", req_ready, 1);
    chk(ovl == ov0, "R12", "read/write overlap", ovl - ov0, 0);
    chk(wcnt - base == ex_n, miss ? "R2" : "R4", "write count", wcnt - base, ex_n);
    for (int j = 0; j < ex_n && j < wcnt - base; j++) begin
      chk(log_a[base+j] == ex_a[j], ex_t[j], "write addr", log_a[base+j], ex_a[j]);
      chk(log_d[base+j] == ex_d[j], ex_t[j], "write data", log_d[base+j], ex_d[j]);
    end
    stuck_en = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
    chk(done == 1'b0, "R1", "done after reset", done, 0);
    chk(!we && !re, "R1", "no access idle", {we, re}, 0);
    // directed
    run_req(0, 800000, 1000000, 400000, 0, 0);   // R4: no safe divider
    run_req(1, 800000, 1000000, 400000, 0, 0);   // R8/R7
    run_req(0, 1000000, 500000, 1200000, 0, 0);  // R3/R5: safe = 2
    run_req(1, 1000000, 500000, 1200000, 0, 0);
    run_req(0, 500000, 800000, 400000, 1, 0);    // R6: keep div1 fields
    run_req(0, 1000000, 500000, 5000000, 0, 0);  // R10: value 9
    run_req(0, 800000, 700000, 400000, 0, 0);    // R2: miss on pre
    run_req(1, 800000, 700000, 400000, 0, 0);    // R2: miss on post
    run_req(0, 800000, 1000000, 400000, 0, 1);   // R9: mux stuck
    run_req(1, 800000, 1000000, 400000, 0, 1);
    // random
    for (int it = 0; it < 40; it++) begin
      logic [31:0] o, n, al;
      o  = T_RATE[$urandom % 3] * 1000;
      n  = T_RATE[$urandom % 3] * 1000;
      if ($urandom % 8 == 0) n = 700000;
      al = $urandom_range(5000000, 100000);
      run_req(1'($urandom % 2), o, n, al, 1'($urandom % 2), ($urandom % 10) == 0);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule